// File: doc/BRIEF.md
# Ethernet Packet Buffer Sequencer

This block sits on the host side of a serial-attached Ethernet controller that keeps its frames in an 8 KB on-chip packet memory. It turns three jobs into ordered streams of abstract commands for a lower-level access engine: a one-time split of the packet memory into a receive area and a transmit area after reset, loading and launching a transmit frame taken from an input byte stream, and fetching one received frame, returning its payload on an output byte stream, then handing that frame's memory back to the controller. The serial signalling and the controller's MAC are handled elsewhere.

Each command is one byte-wide operation: a control register write, a packet memory write, a packet memory read, or a bit-set on a control register. A 16-bit pointer is always written as two register writes. The engine acknowledges each command with `cmd_ack`, and for a memory read it presents the byte on `rd_data` in the same cycle. The sequencer keeps its own copy of the receive tail pointer, so a receive never has to read a pointer back from the controller.

The host issues one request at a time with `req_valid` and `req_kind`. `busy` stays high until the last command of the request has been acknowledged. A one-cycle `done` then reports the byte count: payload bytes sent, or payload bytes delivered.

Top module: `eth_frame_seq`

## Requirements
- R1: After reset, `busy` is high while setup runs. Setup writes these pointers, each at a register address given by a parameter: receive begin = 0x0000 at addresses 8/9, receive end = 0x17FE at 10/11, receive tail = 0x0000 at 12/13, transmit begin = 0x1800 at 4/5 and transmit end = 0x1FFE at 6/7. `busy` then falls.
- R2: Setup ends with a bit-set of mask 0x80 (pointer auto-increment) on register 0x1E, so buffer reads and writes advance the controller's pointers.
- R3: A pointer is written as two back-to-back register writes: the low byte to the even base address first, then the high byte to base+1. Command codes on `cmd_op` are: 0 register write, 1 buffer write, 2 buffer read, 3 bit-set.
- R4: A send writes the buffer write pointer (addresses 2/3) with 0x1800, then writes one control byte 0x00, then writes every payload byte in stream order. A byte is consumed in the cycle `tx_ready` is high, and the byte flagged by `tx_last` is the final one.
- R5: After the payload, a send writes the transmit end pointer (6/7) with 0x1800 + N, where N is the payload byte count. It then bit-sets mask 0x08 on register 0x1F and reports N with `done`.
- R6: A receive first writes the buffer read pointer (0/1) with the saved receive tail, then reads 6 header bytes. Bytes 0 and 1 form the next-frame pointer and bytes 2 and 3 form the frame length, low byte first in both cases.
- R7: The payload length is the frame length minus 4, or 0 when the frame length is below 4. That many bytes are read and presented in order on `rx_data`/`rx_valid`, with `rx_last` on the final byte.
- R8: When the payload length exceeds `rx_limit`, no payload byte is read or presented and `done` reports 0. A payload exactly equal to the limit is delivered.
- R9: Every receive, including a dropped one, ends by writing the receive tail pointer (12/13) with the next-frame pointer and then bit-setting mask 0x40 on register 0x1E. The next receive starts from that pointer.
- R10: Requests are taken only while `busy` is low. A request raised while busy is ignored. `done` is a single-cycle pulse with `busy` already low.
- R11: While `cmd_valid` is high and not acknowledged, `cmd_op`, `cmd_addr` and `cmd_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_kind | input | 1 | 0 send, 1 receive |
| rx_limit | input | 16 | Largest payload the host accepts, sampled at a receive request |
| busy | output | 1 | Setup or a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | 16 | Byte count reported with `done` |
| tx_data | input | 8 | Transmit payload byte |
| tx_valid | input | 1 | Transmit byte present |
| tx_last | input | 1 | Transmit byte is the final one |
| tx_ready | output | 1 | Transmit byte consumed this cycle |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | Received byte present (one cycle) |
| rx_last | output | 1 | Received byte is the final one |
| cmd_valid | output | 1 | Command presented to the access engine |
| cmd_op | output | 2 | Command code |
| cmd_addr | output | 5 | Register address for register writes and bit-sets |
| cmd_data | output | 8 | Write data or bit mask |
| cmd_ack | input | 1 | Engine accepts the current command |
| rd_data | input | 8 | Byte returned by a buffer read, valid with `cmd_ack` |

## Verification
The assertions check the rules that hold on every cycle. A presented command stays frozen until it is acknowledged, `done` is a lone pulse with the block idle, `tx_ready` only coincides with a presented buffer write, `rx_last` only comes with a delivered byte, no payload byte escapes from a frame over the limit, and header capture stays within its four kept bytes. The values and the order of commands can only be shown by the bench's scenarios. Its engine model holds a register file and a packet memory. Against that model, the bench sweeps transmit lengths and frame lengths, including lengths below the CRC size and payloads on either side of the host limit. It then checks the pointer values, the memory contents, the receive tail chaining and the delivered bytes.

// File: rtl/eth_seq_pkg.sv
package eth_seq_pkg;

    localparam int PTR_W     = 16;
    localparam int HDR_BYTES = 6;
    localparam int HDR_KEEP  = 4;
    localparam int CRC_BYTES = 4;

    typedef enum logic [1:0] {
        OP_WREG = 2'd0,
        OP_WBUF = 2'd1,
        OP_RBUF = 2'd2,
        OP_BSET = 2'd3
    } seq_op_e;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_TX_HEAD,
        ST_TX_DATA,
        ST_TX_TAIL,
        ST_RX_HEAD,
        ST_RX_DECIDE,
        ST_RX_DATA,
        ST_RX_TAIL
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic [3:0]       step;
        logic [PTR_W-1:0] cnt;
        logic [PTR_W-1:0] tail;
        logic [PTR_W-1:0] lim;
        logic             done;
        logic [PTR_W-1:0] dcnt;
        logic             rxv;
        logic [7:0]       rxd;
        logic             rxl;
    } seq_regs_t;

endpackage

// File: rtl/eth_seq_hdr.sv
module eth_seq_hdr
    import eth_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [2:0]       cap_idx,
    input  logic [7:0]       cap_byte,
    input  logic [PTR_W-1:0] limit,
    output logic [PTR_W-1:0] next_ptr,
    output logic [PTR_W-1:0] pay_len,
    output logic             too_big
);

    logic [HDR_KEEP-1:0][7:0] hb_q, hb_d;
    logic [PTR_W-1:0]         frame_len;

    for (genvar g = 0; g < HDR_KEEP; g++) begin : g_hdr_byte
        assign hb_d[g] = (cap_en && cap_idx == 3'(g)) ? cap_byte : hb_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hb_q <= '0;
        else        hb_q <= hb_d;
    end

    assign next_ptr  = {hb_q[1], hb_q[0]};
    assign frame_len = {hb_q[3], hb_q[2]};
    assign pay_len   = (frame_len < PTR_W'(CRC_BYTES)) ? '0 : frame_len - PTR_W'(CRC_BYTES);
    assign too_big   = pay_len > limit;

    AST_HDR_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> cap_idx < 3'(HDR_KEEP)); // R6

endmodule

// File: rtl/eth_seq_cmdsel.sv
module eth_seq_cmdsel
    import eth_seq_pkg::*;
#(
    parameter int               AW        = 5,
    parameter logic [AW-1:0]    A_BUF_RD  = 5'h00,
    parameter logic [AW-1:0]    A_BUF_WR  = 5'h02,
    parameter logic [AW-1:0]    A_TX_BEG  = 5'h04,
    parameter logic [AW-1:0]    A_TX_FIN  = 5'h06,
    parameter logic [AW-1:0]    A_RX_BEG  = 5'h08,
    parameter logic [AW-1:0]    A_RX_FIN  = 5'h0A,
    parameter logic [AW-1:0]    A_RX_TAIL = 5'h0C,
    parameter logic [AW-1:0]    A_CTRL2   = 5'h1E,
    parameter logic [AW-1:0]    A_CTRL1   = 5'h1F,
    parameter logic [7:0]       M_TXGO    = 8'h08,
    parameter logic [7:0]       M_PKTDEC  = 8'h40,
    parameter logic [7:0]       M_AUTOINC = 8'h80,
    parameter logic [PTR_W-1:0] RX_FIRST  = 16'h0000,
    parameter logic [PTR_W-1:0] RX_FINAL  = 16'h17FE,
    parameter logic [PTR_W-1:0] TX_FIRST  = 16'h1800,
    parameter logic [PTR_W-1:0] TX_FINAL  = 16'h1FFE,
    parameter int               INIT_LAST = 10
)
(
    input  seq_st_e          st,
    input  logic [3:0]       step,
    input  logic [PTR_W-1:0] rx_tail,
    input  logic [PTR_W-1:0] next_ptr,
    input  logic [PTR_W-1:0] tx_fin,
    input  logic [7:0]       tx_byte,
    output logic [1:0]       op,
    output logic [AW-1:0]    addr,
    output logic [7:0]       data
);

    logic             is_ptr;
    logic [AW-1:0]    pbase;
    logic [PTR_W-1:0] pval;

    always_comb begin
        op     = OP_WREG;
        addr   = '0;
        data   = '0;
        is_ptr = 1'b0;
        pbase  = '0;
        pval   = '0;
        unique case (st)
            ST_INIT: begin
                if (step == 4'(INIT_LAST)) begin
                    op = OP_BSET; addr = A_CTRL2; data = M_AUTOINC;
                end else begin
                    is_ptr = 1'b1;
                    case (step[3:1])
                        3'd0:    begin pbase = A_RX_BEG;  pval = RX_FIRST; end
                        3'd1:    begin pbase = A_RX_FIN;  pval = RX_FINAL; end
                        3'd2:    begin pbase = A_RX_TAIL; pval = RX_FIRST; end
                        3'd3:    begin pbase = A_TX_BEG;  pval = TX_FIRST; end
                        default: begin pbase = A_TX_FIN;  pval = TX_FINAL; end
                    endcase
                end
            end
            ST_TX_HEAD: begin
                if (step == 4'd2) begin
                    op = OP_WBUF; data = 8'h00;
                end else begin
                    is_ptr = 1'b1; pbase = A_BUF_WR; pval = TX_FIRST;
                end
            end
            ST_TX_DATA: begin
                op = OP_WBUF; data = tx_byte;
            end
            ST_TX_TAIL: begin
                if (step == 4'd2) begin
                    op = OP_BSET; addr = A_CTRL1; data = M_TXGO;
                end else begin
                    is_ptr = 1'b1; pbase = A_TX_FIN; pval = tx_fin;
                end
            end
            ST_RX_HEAD: begin
                if (step >= 4'd2) begin
                    op = OP_RBUF;
                end else begin
                    is_ptr = 1'b1; pbase = A_BUF_RD; pval = rx_tail;
                end
            end
            ST_RX_DATA: op = OP_RBUF;
            ST_RX_TAIL: begin
                if (step == 4'd2) begin
                    op = OP_BSET; addr = A_CTRL2; data = M_PKTDEC;
                end else begin
                    is_ptr = 1'b1; pbase = A_RX_TAIL; pval = next_ptr;
                end
            end
            default: ;
        endcase
        if (is_ptr) begin
            addr = pbase + AW'(step[0]);
            data = step[0] ? pval[15:8] : pval[7:0];
        end
    end

endmodule

// File: rtl/eth_frame_seq.sv
module eth_frame_seq
    import eth_seq_pkg::*;
#(
    parameter int            BUF_BYTES = 8192,
    parameter int            AW        = 5,
    parameter logic [AW-1:0] A_BUF_RD  = 5'h00,
    parameter logic [AW-1:0] A_BUF_WR  = 5'h02,
    parameter logic [AW-1:0] A_TX_BEG  = 5'h04,
    parameter logic [AW-1:0] A_TX_FIN  = 5'h06,
    parameter logic [AW-1:0] A_RX_BEG  = 5'h08,
    parameter logic [AW-1:0] A_RX_FIN  = 5'h0A,
    parameter logic [AW-1:0] A_RX_TAIL = 5'h0C,
    parameter logic [AW-1:0] A_CTRL2   = 5'h1E,
    parameter logic [AW-1:0] A_CTRL1   = 5'h1F,
    parameter logic [7:0]    M_TXGO    = 8'h08,
    parameter logic [7:0]    M_PKTDEC  = 8'h40,
    parameter logic [7:0]    M_AUTOINC = 8'h80
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_kind,
    input  logic [15:0]      rx_limit,
    output logic             busy,
    output logic             done,
    output logic [15:0]      done_count,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    input  logic             tx_last,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_last,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [AW-1:0]    cmd_addr,
    output logic [7:0]       cmd_data,
    input  logic             cmd_ack,
    input  logic [7:0]       rd_data
);

    localparam logic [PTR_W-1:0] TX_FIRST  = PTR_W'(BUF_BYTES / 4 * 3);
    localparam logic [PTR_W-1:0] TX_FINAL  = PTR_W'(BUF_BYTES - 2);
    localparam logic [PTR_W-1:0] RX_FIRST  = '0;
    localparam logic [PTR_W-1:0] RX_FINAL  = TX_FIRST - PTR_W'(2);
    localparam int               INIT_LAST = 10;
    localparam logic [3:0]       HDR_LAST  = 4'(2 + HDR_BYTES - 1);

    seq_regs_t        r_q, r_d;
    logic             fire;
    logic             cap_en;
    logic [2:0]       cap_idx;
    logic [PTR_W-1:0] next_ptr, pay_len, tx_fin;
    logic             too_big;

    assign tx_fin = TX_FIRST + r_q.cnt;

    eth_seq_hdr u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_byte (rd_data),
        .limit    (r_q.lim),
        .next_ptr (next_ptr),
        .pay_len  (pay_len),
        .too_big  (too_big)
    );

    eth_seq_cmdsel #(
        .AW(AW), .A_BUF_RD(A_BUF_RD), .A_BUF_WR(A_BUF_WR), .A_TX_BEG(A_TX_BEG),
        .A_TX_FIN(A_TX_FIN), .A_RX_BEG(A_RX_BEG), .A_RX_FIN(A_RX_FIN),
        .A_RX_TAIL(A_RX_TAIL), .A_CTRL2(A_CTRL2), .A_CTRL1(A_CTRL1),
        .M_TXGO(M_TXGO), .M_PKTDEC(M_PKTDEC), .M_AUTOINC(M_AUTOINC),
        .RX_FIRST(RX_FIRST), .RX_FINAL(RX_FINAL), .TX_FIRST(TX_FIRST),
        .TX_FINAL(TX_FINAL), .INIT_LAST(INIT_LAST)
    ) u_cmdsel (
        .st       (r_q.st),
        .step     (r_q.step),
        .rx_tail  (r_q.tail),
        .next_ptr (next_ptr),
        .tx_fin   (tx_fin),
        .tx_byte  (tx_data),
        .op       (cmd_op),
        .addr     (cmd_addr),
        .data     (cmd_data)
    );

    always_comb begin
        case (r_q.st)
            ST_INIT, ST_TX_HEAD, ST_TX_TAIL,
            ST_RX_HEAD, ST_RX_DATA, ST_RX_TAIL: cmd_valid = 1'b1;
            ST_TX_DATA:                        cmd_valid = tx_valid;
            default:                           cmd_valid = 1'b0;
        endcase
    end

    assign fire     = cmd_valid && cmd_ack;
    assign tx_ready = (r_q.st == ST_TX_DATA) && fire;
    assign cap_en   = (r_q.st == ST_RX_HEAD) && fire &&
                      (r_q.step >= 4'd2) && (r_q.step < 4'(2 + HDR_KEEP));
    assign cap_idx  = 3'(r_q.step - 4'd2);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.rxv  = 1'b0;
        r_d.rxl  = 1'b0;
        unique case (r_q.st)
            ST_INIT: if (fire) begin
                if (r_q.step == 4'(INIT_LAST)) begin
                    r_d.st   = ST_IDLE;
                    r_d.step = '0;
                end else begin
                    r_d.step = r_q.step + 4'd1;
                end
            end
            ST_IDLE: if (req_valid) begin
                r_d.step = '0;
                r_d.cnt  = '0;
                if (req_kind) begin
                    r_d.st  = ST_RX_HEAD;
                    r_d.lim = rx_limit;
                end else begin
                    r_d.st  = ST_TX_HEAD;
                end
            end
            ST_TX_HEAD: if (fire) begin
                if (r_q.step == 4'd2) begin
                    r_d.st   = ST_TX_DATA;
                    r_d.step = '0;
                end else begin
                    r_d.step = r_q.step + 4'd1;
                end
            end
            ST_TX_DATA: if (fire) begin
                r_d.cnt = r_q.cnt + PTR_W'(1);
                if (tx_last) r_d.st = ST_TX_TAIL;
            end
            ST_TX_TAIL: if (fire) begin
                if (r_q.step == 4'd2) begin
                    r_d.st   = ST_IDLE;
                    r_d.step = '0;
                    r_d.done = 1'b1;
                    r_d.dcnt = r_q.cnt;
                end else begin
                    r_d.step = r_q.step + 4'd1;
                end
            end
            ST_RX_HEAD: if (fire) begin
                if (r_q.step == HDR_LAST) begin
                    r_d.st   = ST_RX_DECIDE;
                    r_d.step = '0;
                end else begin
                    r_d.step = r_q.step + 4'd1;
                end
            end
            ST_RX_DECIDE: begin
                r_d.st = (pay_len != '0 && !too_big) ? ST_RX_DATA : ST_RX_TAIL;
            end
            ST_RX_DATA: if (fire) begin
                r_d.cnt = r_q.cnt + PTR_W'(1);
                r_d.rxv = 1'b1;
                r_d.rxd = rd_data;
                if (r_q.cnt + PTR_W'(1) == pay_len) begin
                    r_d.rxl = 1'b1;
                    r_d.st  = ST_RX_TAIL;
                end
            end
            ST_RX_TAIL: if (fire) begin
                if (r_q.step == 4'd2) begin
                    r_d.st   = ST_IDLE;
                    r_d.step = '0;
                    r_d.tail = next_ptr;
                    r_d.done = 1'b1;
                    r_d.dcnt = too_big ? '0 : pay_len;
                end else begin
                    r_d.step = r_q.step + 4'd1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_INIT;
            r_q.tail <= RX_FIRST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign done_count = r_q.dcnt;
    assign rx_data    = r_q.rxd;
    assign rx_valid   = r_q.rxv;
    assign rx_last    = r_q.rxl;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_data)); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_TXRDY_WBUF: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> cmd_valid && cmd_op == OP_WBUF); // R4
    AST_RXLAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last |-> rx_valid); // R7
    AST_NO_DROP_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !too_big); // R8
    AST_INIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_INIT |-> r_q.step <= 4'(INIT_LAST)); // R1

endmodule

// File: tb/eth_frame_seq_tb.sv
module eth_frame_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [15:0] rx_limit = '0;
    logic        busy, done;
    logic [15:0] done_count;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_last;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [4:0]  cmd_addr;
    logic [7:0]  cmd_data;
    logic        cmd_ack = 1'b0;
    logic [7:0]  rd_data = '0;

    always #2 clk = ~clk;

    eth_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .rx_limit(rx_limit), .busy(busy), .done(done), .done_count(done_count),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_ack(cmd_ack), .rd_data(rd_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // engine model: register file and packet memory
    logic [7:0] regs [32];
    logic [7:0] mem [int];
    logic [1:0] lg_op [16];
    logic [4:0] lg_ad [16];
    logic [7:0] lg_dt [16];
    int  lcnt = 0;
    int  ack_gap = 0;
    int  wait_cnt = 0;
    int  order_err = 0;
    bit  consume_pend = 0;
    bit  last_wreg = 0;
    logic [4:0] last_ad = '0;

    // transmit source
    logic [7:0] txbuf [64];
    int  tx_n = 0;
    int  tx_idx = 0;
    bit  tx_act = 0;
    assign tx_valid = tx_act && (tx_idx < tx_n);
    assign tx_data  = txbuf[tx_idx[5:0]];
    assign tx_last  = (tx_idx == tx_n - 1);

    function automatic logic [7:0] mrd(input int a);
        return mem.exists(a & 16'h1FFF) ? mem[a & 16'h1FFF] : 8'h00;
    endfunction

    task automatic do_cmd();
        logic [15:0] p;
        case (cmd_op)
            2'd0: begin
                if (cmd_addr < 5'd14 && cmd_addr[0] && !(last_wreg && last_ad == cmd_addr - 5'd1))
                    order_err++;
                regs[cmd_addr] = cmd_data;
            end
            2'd1: begin
                p = {regs[3], regs[2]};
                mem[int'(p) & 16'h1FFF] = cmd_data;
                if (regs[30][7]) begin p = p + 16'd1; regs[2] = p[7:0]; regs[3] = p[15:8]; end
            end
            2'd2: begin
                p = {regs[1], regs[0]};
                rd_data = mrd(int'(p));
                if (regs[30][7]) begin p = p + 16'd1; regs[0] = p[7:0]; regs[1] = p[15:8]; end
            end
            default: regs[cmd_addr] = regs[cmd_addr] | cmd_data;
        endcase
        if ((cmd_op == 2'd0 || cmd_op == 2'd3) && lcnt < 16) begin
            lg_op[lcnt] = cmd_op; lg_ad[lcnt] = cmd_addr; lg_dt[lcnt] = cmd_data;
            lcnt++;
        end
        last_wreg = (cmd_op == 2'd0);
        last_ad   = cmd_addr;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_ack = 1'b0;
            wait_cnt = 0;
        end else if (cmd_ack) begin
            cmd_ack = 1'b0;
            if (consume_pend) begin tx_idx++; consume_pend = 0; end
        end else if (cmd_valid) begin
            if (wait_cnt < ack_gap) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                do_cmd();
                cmd_ack = 1'b1;
                #1;
                consume_pend = tx_ready;
            end
        end
    end

    // output monitors
    logic [7:0] rxcap [64];
    int  rx_got = 0;
    int  rx_last_at = -1;
    bit  done_seen = 0;
    int  done_val = 0;
    int  done_pulses = 0;
    always @(negedge clk) begin
        if (rx_valid) begin
            if (rx_got < 64) rxcap[rx_got] = rx_data;
            if (rx_last) rx_last_at = rx_got;
            rx_got++;
        end
        if (done) begin done_seen = 1; done_val = int'(done_count); done_pulses++; end
    end

    task automatic wait_done();
        for (int i = 0; i < 4000 && !done_seen; i++) @(negedge clk);
        chk(done_seen, "R10", "done pulse seen", int'(done_seen), 1);
    endtask

    task automatic do_send(input int n, input bit disturb);
        int bad;
        for (int i = 0; i < n; i++) txbuf[i] = 8'((n * 13 + i * 7 + 1) & 8'hFF);
        mem[16'h1800] = 8'hAA;
        regs[31] = 8'h00;
        lcnt = 0; tx_n = n; tx_idx = 0; tx_act = 1; done_seen = 0;
        @(negedge clk); req_kind = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R10", "busy after send accept", int'(busy), 1);
        if (disturb) begin
            req_kind = 1'b1;
            for (int i = 0; i < 6; i++) @(negedge clk);
        end
        req_valid = 1'b0;
        wait_done();
        tx_act = 0;
        chk(done_val == n, "R5", "send done_count", done_val, n);
        chk(mrd(16'h1800) == 8'h00, "R4", "control byte", int'(mrd(16'h1800)), 0);
        bad = 0;
        for (int i = 0; i < n; i++) if (mrd(16'h1801 + i) != txbuf[i]) bad++;
        chk(bad == 0, "R4", "payload bytes mismatched", bad, 0);
        chk({regs[7], regs[6]} == 16'(16'h1800 + n), "R5", "transmit end pointer",
            int'({regs[7], regs[6]}), 16'h1800 + n);
        chk(regs[31][3] == 1'b1, "R5", "transmit request bit", int'(regs[31]), 8'h08);
        bad = (lcnt != 5) ? 1 : 0;
        if (lcnt == 5) begin
            if (lg_op[0] != 0 || lg_ad[0] != 2 || lg_dt[0] != 8'h00) bad++;
            if (lg_op[1] != 0 || lg_ad[1] != 3 || lg_dt[1] != 8'h18) bad++;
            if (lg_op[2] != 0 || lg_ad[2] != 6 || lg_dt[2] != 8'((16'h1800 + n) & 8'hFF)) bad++;
            if (lg_op[3] != 0 || lg_ad[3] != 7 || lg_dt[3] != 8'((16'h1800 + n) >> 8)) bad++;
            if (lg_op[4] != 3 || lg_ad[4] != 31 || lg_dt[4] != 8'h08) bad++;
        end
        chk(bad == 0, "R3", "send control command sequence", lcnt, 5);
        if (disturb) begin
            bad = 0;
            for (int i = 0; i < 12; i++) begin @(negedge clk); if (cmd_valid || busy) bad++; end
            chk(bad == 0, "R10", "request during busy ignored", bad, 0);
        end
    endtask

    int tail = 0;

    task automatic do_recv(input int frm, input int lim);
        int nxt, pay, expc, bad;
        nxt = tail + 6 + frm;
        if (nxt[0]) nxt++;
        mem[tail & 16'h1FFF]       = 8'(nxt & 8'hFF);
        mem[(tail + 1) & 16'h1FFF] = 8'(nxt >> 8);
        mem[(tail + 2) & 16'h1FFF] = 8'(frm & 8'hFF);
        mem[(tail + 3) & 16'h1FFF] = 8'(frm >> 8);
        mem[(tail + 4) & 16'h1FFF] = 8'h5A;
        mem[(tail + 5) & 16'h1FFF] = 8'hC3;
        for (int i = 0; i < frm; i++) mem[(tail + 6 + i) & 16'h1FFF] = 8'((frm * 3 + i * 11 + 5) & 8'hFF);
        pay  = (frm < 4) ? 0 : frm - 4;
        expc = (pay > lim) ? 0 : pay;
        regs[30] = regs[30] & 8'hBF;
        lcnt = 0; rx_got = 0; rx_last_at = -1; done_seen = 0;
        @(negedge clk); req_kind = 1'b1; req_valid = 1'b1; rx_limit = 16'(lim);
        @(negedge clk); req_valid = 1'b0;
        wait_done();
        chk(done_val == expc, (pay > lim) ? "R8" : "R7", "receive done_count", done_val, expc);
        chk(rx_got == expc, (pay > lim) ? "R8" : "R7", "bytes delivered", rx_got, expc);
        bad = 0;
        for (int i = 0; i < expc && i < 64; i++) if (rxcap[i] != mrd(tail + 6 + i)) bad++;
        chk(bad == 0, "R7", "payload byte mismatches", bad, 0);
        chk(rx_last_at == expc - 1, "R7", "rx_last position", rx_last_at, expc - 1);
        chk({regs[13], regs[12]} == 16'(nxt), "R9", "receive tail pointer",
            int'({regs[13], regs[12]}), nxt);
        chk(regs[30][6] == 1'b1, "R9", "packet decrement bit", int'(regs[30]), 8'h40);
        bad = (lcnt != 5) ? 1 : 0;
        if (lcnt == 5) begin
            if (lg_op[0] != 0 || lg_ad[0] != 0 || lg_dt[0] != 8'(tail & 8'hFF)) bad++;
            if (lg_op[1] != 0 || lg_ad[1] != 1 || lg_dt[1] != 8'(tail >> 8)) bad++;
            if (lg_op[2] != 0 || lg_ad[2] != 12 || lg_dt[2] != 8'(nxt & 8'hFF)) bad++;
            if (lg_op[3] != 0 || lg_ad[3] != 13 || lg_dt[3] != 8'(nxt >> 8)) bad++;
            if (lg_op[4] != 3 || lg_ad[4] != 30 || lg_dt[4] != 8'h40) bad++;
        end
        chk(bad == 0, "R6", "receive read start and command sequence", lcnt, 5);
        tail = nxt;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int bad;
        for (int i = 0; i < 32; i++) regs[i] = 8'hFF;
        regs[30] = 8'h00;
        regs[31] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R1", "busy during setup", int'(busy), 1);
        chk(done == 1'b0 && rx_valid == 1'b0, "R1", "idle outputs at reset", int'({done, rx_valid}), 0);
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        chk(busy == 1'b0, "R1", "setup finished", int'(busy), 0);
        chk({regs[9], regs[8]} == 16'h0000, "R1", "receive begin", int'({regs[9], regs[8]}), 16'h0000);
        chk({regs[11], regs[10]} == 16'h17FE, "R1", "receive end", int'({regs[11], regs[10]}), 16'h17FE);
        chk({regs[13], regs[12]} == 16'h0000, "R1", "receive tail", int'({regs[13], regs[12]}), 16'h0000);
        chk({regs[5], regs[4]} == 16'h1800, "R1", "transmit begin", int'({regs[5], regs[4]}), 16'h1800);
        chk({regs[7], regs[6]} == 16'h1FFE, "R1", "transmit end", int'({regs[7], regs[6]}), 16'h1FFE);
        bad = (lcnt == 11 && lg_op[10] == 3 && lg_ad[10] == 30 && lg_dt[10] == 8'h80) ? 0 : 1;
        chk(bad == 0, "R2", "auto-increment enable last in setup", lcnt, 11);
        chk(regs[30][7] == 1'b1, "R2", "auto-increment bit", int'(regs[30]), 8'h80);

        for (int n = 1; n <= 24; n++) begin
            ack_gap = n % 3;
            do_send(n, 1'b0);
        end
        ack_gap = 2;
        do_send(8, 1'b1);

        for (int f = 0; f <= 40; f++) begin
            ack_gap = f % 2;
            do_recv(f, (f % 5 == 0) ? 10 : 64);
        end
        ack_gap = 0;
        do_recv(14, 10);
        do_recv(15, 10);
        do_recv(5, 0);
        do_recv(9, 5);

        chk(order_err == 0, "R3", "pointer low-before-high violations", order_err, 0);
        chk(done_pulses == 24 + 1 + 41 + 4, "R10", "done pulse count", done_pulses, 70);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule